// File: doc/BRIEF.md
# Custom Instruction-Group Decoder with Software Prefetch

This block is a purely combinational decoder for a 32-bit RISC-V-style instruction word. It owns a single reserved major opcode (0x6B in bits [6:0]). A 3-bit function field divides that opcode into five warp-control operations and one software prefetch. When the opcode is present, the block reports whether the word belongs to the group. For legal words it then supplies the unit steering, the register indices, the writeback enable, a sign-extended immediate and an operation code. Any other opcode raises neither valid nor illegal, and every payload output reads zero. The general decoder can therefore OR this block's outputs into its own.

The prefetch is steered to the load/store unit and carries the load-word operation code, so the unit handles it as an ordinary load. Its writeback enable is forced low, so the returned data is dropped and no register is written. Function values 6 and 7 under the owned opcode are flagged illegal and select no unit.

Top module: `cdec_top`

## Requirements
- R1: `grp_hit_o` is 1 exactly when bits [6:0] of the word equal 0x6B.
- R2: When the opcode is not 0x6B, the following outputs are all zero: `valid_o`, `illegal_o`, `unit_sel_o`, `rs1_o`, `rs2_o`, `rd_o`, `wb_en_o`, `imm_o` and `op_o`.
- R3: Under opcode 0x6B, function field bits [14:12] with values 0, 1, 2, 3 and 4 give `valid_o`=1 and `unit_sel_o`=2'b01 (warp-control unit). They give `op_o` = 4'h8, 4'h9, 4'hA, 4'hB and 4'hC respectively.
- R4: Under opcode 0x6B, function value 5 is the prefetch. It gives `valid_o`=1, `unit_sel_o`=2'b10 (load/store unit) and `op_o`=4'h2, the load-word code, whose bit 3 is 0.
- R5: `wb_en_o` is 0 for every word, and in particular for the prefetch.
- R6: For a valid word, `imm_o` is bits [31:20] sign-extended to 32 bits, with bit 31 copied into bits [31:12].
- R7: For a valid word, `rs1_o`, `rs2_o` and `rd_o` equal bits [19:15], [24:20] and [11:7] respectively.
- R8: Under opcode 0x6B, function values 6 and 7 give `illegal_o`=1, `valid_o`=0 and `unit_sel_o`=0. In that case the register, immediate and operation outputs are all 0.
- R9: The word 0x0007506B decodes as a prefetch with `rs1_o`=14, `rd_o`=0 and `imm_o`=0.
- R10: `valid_o` and `illegal_o` are never both 1, and `unit_sel_o` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| grp_hit_o | output | 1 | Word carries the owned major opcode |
| valid_o | output | 1 | Legal member of the group |
| illegal_o | output | 1 | Owned opcode with an unassigned function value |
| unit_sel_o | output | 2 | One-hot unit select: bit 0 warp control, bit 1 load/store |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| wb_en_o | output | 1 | Register writeback enable |
| imm_o | output | 32 | Sign-extended immediate |
| op_o | output | 4 | Operation code for the selected unit |

## Verification
The assertions treat the instruction word as a fully known 32-bit value with no X or Z bits, because the decode is evaluated whenever the word settles. The stimulus meets this condition by always driving whole words from `$urandom`. About half of the random words have their opcode forced to 0x6B, so all eight function values appear often under the owned opcode, alongside foreign opcodes. Directed words add the fixed prefetch encoding and sign-bit extremes of the immediate.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

  typedef enum logic [1:0] {
    UNIT_NONE = 2'b00,
    UNIT_WCTL = 2'b01,
    UNIT_LSU  = 2'b10
  } unit_e;

  typedef enum logic [3:0] {
    OPC_NONE   = 4'h0,
    OPC_LOADW  = 4'h2,
    OPC_TMC    = 4'h8,
    OPC_WSPAWN = 4'h9,
    OPC_SPLIT  = 4'hA,
    OPC_JOIN   = 4'hB,
    OPC_BAR    = 4'hC
  } opc_e;

  typedef struct packed {
    logic  legal;
    unit_e unit;
    opc_e  op;
    logic  wb;
  } fdesc_t;

  localparam int unsigned FUNC_W     = 3;
  localparam int unsigned NFUNC      = 1 << FUNC_W;
  localparam int unsigned FUNC_PFTCH = 5;

  function automatic fdesc_t describe(input int unsigned f);
    fdesc_t d;
    d = '{legal: 1'b0, unit: UNIT_NONE, op: OPC_NONE, wb: 1'b0};
    case (f)
      0: d = '{legal: 1'b1, unit: UNIT_WCTL, op: OPC_TMC,    wb: 1'b0};
      1: d = '{legal: 1'b1, unit: UNIT_WCTL, op: OPC_WSPAWN, wb: 1'b0};
      2: d = '{legal: 1'b1, unit: UNIT_WCTL, op: OPC_SPLIT,  wb: 1'b0};
      3: d = '{legal: 1'b1, unit: UNIT_WCTL, op: OPC_JOIN,   wb: 1'b0};
      4: d = '{legal: 1'b1, unit: UNIT_WCTL, op: OPC_BAR,    wb: 1'b0};
      FUNC_PFTCH: d = '{legal: 1'b1, unit: UNIT_LSU, op: OPC_LOADW, wb: 1'b0};
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cdec_fields.sv
module cdec_fields #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned REG_W = 5
) (
  input  logic [31:0]                  instr_i,
  output logic [6:0]                   opc_o,
  output logic [cdec_pkg::FUNC_W-1:0]  func_o,
  output logic [REG_W-1:0]             rs1_o,
  output logic [REG_W-1:0]             rs2_o,
  output logic [REG_W-1:0]             rd_o,
  output logic [XLEN-1:0]              imm_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  assign opc_o  = instr_i[6:0];
  assign func_o = instr_i[12 +: cdec_pkg::FUNC_W];
  assign rd_o   = instr_i[7 +: REG_W];
  assign rs1_o  = instr_i[15 +: REG_W];
  assign rs2_o  = instr_i[20 +: REG_W];

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_o = {{EXT_W{instr_i[31]}}, instr_i[31 -: IMM_W]};
    end else begin : g_noext
      assign imm_o = instr_i[31 -: XLEN];
    end
  endgenerate
endmodule

// File: rtl/cdec_functab.sv
module cdec_functab (
  input  logic [cdec_pkg::FUNC_W-1:0] func_i,
  output cdec_pkg::fdesc_t            desc_o
);
  import cdec_pkg::*;

  fdesc_t tab [NFUNC];

  generate
    for (genvar g = 0; g < NFUNC; g++) begin : g_row
      assign tab[g] = describe(g);
    end
  endgenerate

  assign desc_o = tab[func_i];
endmodule

// File: rtl/cdec_top.sv
module cdec_top #(
  parameter logic [6:0]  GRP_OPC = 7'h6B,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IMM_W   = 12,
  parameter int unsigned REG_W   = 5
) (
  input  logic [31:0]      instr_i,
  output logic             grp_hit_o,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [1:0]       unit_sel_o,
  output logic [REG_W-1:0] rs1_o,
  output logic [REG_W-1:0] rs2_o,
  output logic [REG_W-1:0] rd_o,
  output logic             wb_en_o,
  output logic [XLEN-1:0]  imm_o,
  output logic [3:0]       op_o
);
  import cdec_pkg::*;

  logic [6:0]        f_opc;
  logic [FUNC_W-1:0] f_func;
  logic [REG_W-1:0]  f_rs1, f_rs2, f_rd;
  logic [XLEN-1:0]   f_imm;
  fdesc_t            desc;
  logic              hit, legal;

  cdec_fields #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_W(REG_W)) u_fields (
    .instr_i (instr_i),
    .opc_o   (f_opc),
    .func_o  (f_func),
    .rs1_o   (f_rs1),
    .rs2_o   (f_rs2),
    .rd_o    (f_rd),
    .imm_o   (f_imm)
  );

  cdec_functab u_tab (
    .func_i (f_func),
    .desc_o (desc)
  );

  assign hit   = (f_opc == GRP_OPC);
  assign legal = hit & desc.legal;

  always_comb begin
    grp_hit_o  = hit;
    valid_o    = legal;
    illegal_o  = hit & ~desc.legal;
    unit_sel_o = legal ? desc.unit : UNIT_NONE;
    op_o       = legal ? desc.op   : OPC_NONE;
    wb_en_o    = legal & desc.wb;
    rs1_o      = legal ? f_rs1 : '0;
    rs2_o      = legal ? f_rs2 : '0;
    rd_o       = legal ? f_rd  : '0;
    imm_o      = legal ? f_imm : '0;
  end

  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R10
      excl_flags_chk: assert (!(valid_o && illegal_o))
        else $error("valid and illegal both high");
      // R10
      unit_onehot_chk: assert ($onehot0(unit_sel_o))
        else $error("unit select not one-hot");
      // R4
      lsu_is_load_chk: assert (!(unit_sel_o == 2'b10) || (op_o[3] == 1'b0))
        else $error("load/store op without load encoding");
      // R5
      pf_no_wb_chk: assert (!(unit_sel_o == 2'b10) || !wb_en_o)
        else $error("prefetch enables writeback");
      // R2
      foreign_quiet_chk: assert (grp_hit_o || (unit_sel_o == 2'b00 && op_o == 4'h0 && !valid_o))
        else $error("foreign opcode produced decode");
      // R8
      illegal_nounit_chk: assert (!illegal_o || (unit_sel_o == 2'b00 && op_o == 4'h0))
        else $error("illegal word selected a unit");
    end
  end
endmodule

// File: tb/sim_cdec_top.sv
module sim_cdec_top;
  logic        clk = 1'b0;
  logic [31:0] instr;
  logic        hit, vld, ill, wb;
  logic [1:0]  usel;
  logic [4:0]  rs1, rs2, rd;
  logic [31:0] imm;
  logic [3:0]  op;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdec_top u0 (
    .instr_i(instr), .grp_hit_o(hit), .valid_o(vld), .illegal_o(ill),
    .unit_sel_o(usel), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd),
    .wb_en_o(wb), .imm_o(imm), .op_o(op)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s instr=%08h actual=%0h expected=%0h", tag, instr, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_op(input logic [2:0] f);
    case (f)
      3'd0: return 4'h8;
      3'd1: return 4'h9;
      3'd2: return 4'hA;
      3'd3: return 4'hB;
      3'd4: return 4'hC;
      3'd5: return 4'h2;
      default: return 4'h0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] w);
    logic g, legal;
    logic [2:0] f;
    string tag;
    @(negedge clk);
    instr = w;
    @(posedge clk);
    #1;
    g = (w[6:0] == 7'h6B);
    f = w[14:12];
    legal = g && (f <= 3'd5);
    chk("R1 hit", 64'(hit), 64'(g));
    chk("R5 wb_en", 64'(wb), 64'(0));
    if (!g) tag = "R2";
    else if (f < 3'd5) tag = "R3";
    else if (f == 3'd5) tag = "R4";
    else tag = "R8";
    chk({tag, " valid"}, 64'(vld), 64'(legal));
    chk({tag, " illegal"}, 64'(ill), 64'(g && !legal));
    chk({tag, " unit"}, 64'(usel),
        64'(!legal ? 2'b00 : (f == 3'd5 ? 2'b10 : 2'b01)));
    chk({tag, " op"}, 64'(op), 64'(legal ? exp_op(f) : 4'h0));
    chk(legal ? "R6 imm" : {tag, " imm"}, 64'(imm),
        64'(legal ? {{20{w[31]}}, w[31:20]} : 32'h0));
    chk(legal ? "R7 regs" : {tag, " regs"}, 64'({rs1, rs2, rd}),
        64'(legal ? {w[19:15], w[24:20], w[11:7]} : 15'h0));
    chk("R10 excl", 64'(vld & ill), 64'(0));
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'd20240611);
    instr = 32'h0;
    repeat (2) @(posedge clk);
    // reset-like start: all-zero word is foreign (R2)
    apply(32'h0000_0000);
    // R9 fixed prefetch word
    apply(32'h0007_506B);
    chk("R9 rs1", 64'(rs1), 64'(14));
    chk("R9 rd", 64'(rd), 64'(0));
    chk("R9 imm", 64'(imm), 64'(0));
    chk("R9 unit", 64'(usel), 64'(2'b10));
    // R6 sign extremes
    apply(32'hFFF0_506B);
    apply(32'h7FF0_506B);
    apply(32'h8000_006B);
    // each function value directed (R3 R4 R8)
    for (int f = 0; f < 8; f++) apply({17'h1ABCD, 3'(f), 5'd9, 7'h6B});
    // near-miss opcodes (R1 R2)
    apply(32'h0007_506A);
    apply(32'h0007_502B);
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      if (i[0]) r[6:0] = 7'h6B;
      apply(r);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule